// File: doc/BRIEF.md
# Dual-Bus Bidirectional Shift Register

An eight-stage register placed between two 8-bit parallel buses, A and B, with a one-bit serial input. A direction select decides which bus feeds the register and which bus the register drives. In parallel mode the register takes a whole word from the source bus. In serial mode it shifts one position per clock. When bus A is the source but is not enabled, the register holds its value by reloading itself. Bus pins are modelled as separate in, out and output-enable vectors, so the block fits a synthesizable fabric.

A parallel load can be clocked, or it can be immediate. In immediate mode a combinational bypass shows the source word on the stage outputs and on the driven bus in the same cycle, and the word is stored at the next clock edge. Longer words are built by wiring the serial output of one register into the serial input of the next.

Top module: `dual_bus_shreg`

## Requirements
- R1: `rst` is synchronous and active high. A clock edge with `rst` high clears every stage to zero. While `rst` is high, `a_oe` and `b_oe` are all zero.
- R2: With `dir_a2b`=1, `par_mode`=1, `a_en`=1 and `async_ld`=0, a clock edge stores `a_in` in the stages. B is the driven bus: `b_oe` is all ones, `b_out` equals `q`, and `a_oe` is all zero.
- R3: With `dir_a2b`=0 and `par_mode`=1, a clock edge stores `b_in`. When `a_en`=1, `a_oe` is all ones and `a_out` equals `q`. In this direction `b_oe` is all zero.
- R4: With `dir_a2b`=0 and `a_en`=0, `a_oe` is all zero (A lines high-impedance). Loads from B still take place.
- R5: With `dir_a2b`=1, `par_mode`=1 and `a_en`=0, the register recirculates. `q` after the edge equals `q` before it, whatever `a_in` is.
- R6: With `par_mode`=0, each rising edge moves stage i-1 into stage i (stage 0 is bit 0) and loads `ser_in` into stage 0, whatever the direction.
- R7: `ser_out` always equals the stored value of the last stage (bit 7), without the async bypass.
- R8: With `par_mode`=1, `async_ld`=1 and no recirculation, `q` and the driven bus show the source word in the same cycle. The word stays stored after the next edge.
- R9: When the serial output of one register feeds the serial input of a second register, eight serial clocks move the first register's old word into the second register.
- R10: `a_oe` and `b_oe` are never nonzero at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single-phase clock |
| rst | input | 1 | Synchronous active-high reset |
| a_en | input | 1 | Enable for the A lines |
| async_ld | input | 1 | 1: parallel load shows at once; 0: at the clock edge |
| dir_a2b | input | 1 | 1: A is source and B is driven; 0: B is source and A is driven |
| par_mode | input | 1 | 1: parallel load; 0: serial shift |
| ser_in | input | 1 | Serial data into stage 0 |
| a_in | input | 8 | A bus input value |
| a_out | output | 8 | A bus drive value |
| a_oe | output | 8 | A bus output enables |
| b_in | input | 8 | B bus input value |
| b_out | output | 8 | B bus drive value |
| b_oe | output | 8 | B bus output enables |
| q | output | 8 | Stage outputs, including the async bypass |
| ser_out | output | 1 | Stored last-stage value |

## Verification
The clocked assertions take the mode controls to be stable across each edge and free of X after reset. The bench meets this by changing every input only on the falling clock edge. The recirculation and shift properties assume `ser_in` and the bus inputs are known values at the edge. The random stimulus draws them from `$urandom` and never leaves them undriven. Directed cases cover the async bypass and reset, while the random mix switches direction, mode and enable freely on every cycle.

// File: rtl/dbsr_pkg.sv
package dbsr_pkg;
  typedef enum logic [1:0] {
    OP_SHIFT = 2'd0,
    OP_LOAD  = 2'd1,
    OP_HOLD  = 2'd2
  } dbsr_op_e;
endpackage

// File: rtl/dbsr_ctrl.sv
module dbsr_ctrl
  import dbsr_pkg::*;
(
  input  logic     rst,
  input  logic     a_en,
  input  logic     async_ld,
  input  logic     dir_a2b,
  input  logic     par_mode,
  output dbsr_op_e op,
  output logic     bypass,
  output logic     drive_a,
  output logic     drive_b
);
  logic recirc;

  always_comb begin
    recirc = dir_a2b && !a_en;
    if (!par_mode)   op = OP_SHIFT;
    else if (recirc) op = OP_HOLD;
    else             op = OP_LOAD;
    bypass  = !rst && par_mode && async_ld && !recirc;
    drive_a = !rst && !dir_a2b && a_en;
    drive_b = !rst && dir_a2b;
  end
endmodule

// File: rtl/dbsr_stages.sv
module dbsr_stages
  import dbsr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  dbsr_op_e     op,
  input  logic         ser_in,
  input  logic [W-1:0] din,
  output logic [W-1:0] st
);
  logic [W-1:0] shv;
  assign shv = {st[W-2:0], ser_in};

  for (genvar g = 0; g < W; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[g] <= 1'b0;
      else begin
        case (op)
          OP_SHIFT: st[g] <= shv[g];
          OP_LOAD:  st[g] <= din[g];
          default:  st[g] <= st[g];
        endcase
      end
    end
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    op == OP_HOLD |=> st == $past(st)); // R5
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
    op == OP_SHIFT |=> (st[0] == $past(ser_in)) && (st[W-1:1] == $past(st[W-2:0]))); // R6
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    op == OP_LOAD |=> st == $past(din)); // R2
  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> st == '0); // R1
endmodule

// File: rtl/dbsr_bus.sv
module dbsr_bus #(
  parameter int W = 8
) (
  input  logic         dir_a2b,
  input  logic         bypass,
  input  logic         drive_a,
  input  logic         drive_b,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] st,
  output logic [W-1:0] din,
  output logic [W-1:0] vis,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  assign din = dir_a2b ? a_in : b_in;
  assign vis = bypass ? din : st;

  for (genvar g = 0; g < W; g++) begin : g_pin
    assign a_out[g] = vis[g];
    assign b_out[g] = vis[g];
    assign a_oe[g]  = drive_a;
    assign b_oe[g]  = drive_b;
  end

  always_comb begin
    AST_ONE_DRIVER: assert (!(drive_a && drive_b)); // R10
  end
endmodule

// File: rtl/dual_bus_shreg.sv
module dual_bus_shreg
  import dbsr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         a_en,
  input  logic         async_ld,
  input  logic         dir_a2b,
  input  logic         par_mode,
  input  logic         ser_in,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  output logic [W-1:0] q,
  output logic         ser_out
);
  localparam int LAST = W - 1;

  dbsr_op_e     op;
  logic         bypass, drive_a, drive_b;
  logic [W-1:0] din, st, vis;

  dbsr_ctrl u_ctrl (
    .rst(rst), .a_en(a_en), .async_ld(async_ld), .dir_a2b(dir_a2b),
    .par_mode(par_mode), .op(op), .bypass(bypass),
    .drive_a(drive_a), .drive_b(drive_b)
  );

  dbsr_stages #(.W(W)) u_stages (
    .clk(clk), .rst(rst), .op(op), .ser_in(ser_in), .din(din), .st(st)
  );

  dbsr_bus #(.W(W)) u_bus (
    .dir_a2b(dir_a2b), .bypass(bypass), .drive_a(drive_a), .drive_b(drive_b),
    .a_in(a_in), .b_in(b_in), .st(st), .din(din), .vis(vis),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  assign q       = vis;
  assign ser_out = st[LAST];

  AST_RST_RELEASE: assert property (@(posedge clk)
    rst |-> (a_oe == '0) && (b_oe == '0)); // R1
  AST_A_HIZ: assert property (@(posedge clk) disable iff (rst)
    (!dir_a2b && !a_en) |-> a_oe == '0); // R4
  AST_SEROUT_TRACK: assert property (@(posedge clk) disable iff (rst)
    (par_mode == 1'b0) |=> ser_out == $past(st[LAST-1])); // R7
  AST_ASYNC_SHOW: assert property (@(posedge clk) disable iff (rst)
    (par_mode && async_ld && !(dir_a2b && !a_en)) |-> q == din); // R8
endmodule

// File: tb/sim_dual_bus_shreg.sv
module sim_dual_bus_shreg;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_en = 1'b0, async_ld = 1'b0, dir_a2b = 1'b1, par_mode = 1'b1, ser_in = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out0, a_oe0, b_out0, b_oe0, q0;
  logic [W-1:0] a_out1, a_oe1, b_out1, b_oe1, q1;
  logic so0, so1;

  int checks = 0, fails = 0;
  logic [W-1:0] m0 = '0, m1 = '0;

  always #10 clk = ~clk;

  dual_bus_shreg #(.W(W)) u0 (
    .clk(clk), .rst(rst), .a_en(a_en), .async_ld(async_ld), .dir_a2b(dir_a2b),
    .par_mode(par_mode), .ser_in(ser_in), .a_in(a_in), .a_out(a_out0), .a_oe(a_oe0),
    .b_in(b_in), .b_out(b_out0), .b_oe(b_oe0), .q(q0), .ser_out(so0)
  );

  dual_bus_shreg #(.W(W)) u1 (
    .clk(clk), .rst(rst), .a_en(a_en), .async_ld(async_ld), .dir_a2b(dir_a2b),
    .par_mode(par_mode), .ser_in(so0), .a_in(a_in), .a_out(a_out1), .a_oe(a_oe1),
    .b_in(b_in), .b_out(b_out1), .b_oe(b_oe1), .q(q1), .ser_out(so1)
  );

  function automatic logic [W-1:0] f_next(logic [W-1:0] cur, logic sin);
    if (!par_mode) return {cur[W-2:0], sin};
    if (dir_a2b && !a_en) return cur;
    return dir_a2b ? a_in : b_in;
  endfunction

  function automatic logic [W-1:0] f_vis(logic [W-1:0] cur);
    if (!rst && par_mode && async_ld && !(dir_a2b && !a_en))
      return dir_a2b ? a_in : b_in;
    return cur;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outs();
    logic [W-1:0] ea, eb, v0;
    ea = (!rst && !dir_a2b && a_en) ? '1 : '0;
    eb = (!rst && dir_a2b) ? '1 : '0;
    v0 = f_vis(m0);
    chk(q0 == v0, (par_mode && async_ld) ? "R8 q" : "R2/R3 q", q0, v0);
    chk(q1 == f_vis(m1), "R9 q cascade", q1, f_vis(m1));
    chk(a_oe0 == ea, dir_a2b ? "R2 a_oe" : (a_en ? "R3 a_oe" : "R4 a_oe"), a_oe0, ea);
    chk(b_oe0 == eb, dir_a2b ? "R2 b_oe" : "R3 b_oe", b_oe0, eb);
    chk(!(|a_oe0 && |b_oe0), "R10 one driver", a_oe0, b_oe0);
    if (|b_oe0) chk(b_out0 == v0, "R2 b_out", b_out0, v0);
    if (|a_oe0) chk(a_out0 == v0, "R3 a_out", a_out0, v0);
    chk(so0 == m0[W-1], "R7 ser_out", {7'd0, so0}, {7'd0, m0[W-1]});
  endtask

  task automatic step();
    logic [W-1:0] n0, n1;
    #1 check_outs();
    n0 = f_next(m0, ser_in);
    n1 = f_next(m1, m0[W-1]);
    @(posedge clk);
    if (rst) begin m0 = '0; m1 = '0; end
    else begin m0 = n0; m1 = n1; end
    @(negedge clk);
  endtask

  task automatic setc(input logic d, input logic p, input logic e, input logic s);
    dir_a2b = d; par_mode = p; a_en = e; async_ld = s;
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    a_en = 1'b1;
    #1 chk(a_oe0 == '0 && b_oe0 == '0, "R1 buses released in reset", a_oe0 | b_oe0, '0);
    step();
    step();
    rst = 1'b0;
    #1 chk(q0 == '0, "R1 stages cleared", q0, '0);
    chk(q1 == '0, "R1 stages cleared u1", q1, '0);
    @(negedge clk);

    // R2: A to B, clocked
    setc(1, 1, 1, 0); a_in = 8'hA5; step();
    chk(q0 == 8'hA5, "R2 load A", q0, 8'hA5);
    // R3: B to A
    setc(0, 1, 1, 0); b_in = 8'h3C; step();
    chk(a_out0 == 8'h3C && a_oe0 == '1, "R3 A driven", a_out0, 8'h3C);
    // R4: A released, load from B still occurs
    setc(0, 1, 0, 0); b_in = 8'h71; step();
    chk(a_oe0 == '0, "R4 A hi-z", a_oe0, '0);
    chk(q0 == 8'h71, "R4 B load while A hi-z", q0, 8'h71);
    // R5: recirculation ignores a_in
    setc(1, 1, 0, 0); a_in = 8'hFF; step(); a_in = 8'h00; step();
    chk(q0 == 8'h71, "R5 hold", q0, 8'h71);
    // R6/R9: eight serial clocks
    setc(1, 0, 1, 0);
    for (int i = W - 1; i >= 0; i--) begin
      ser_in = 8'hC9 >> i; step();
    end
    chk(q0 == 8'hC9, "R6 serial word", q0, 8'hC9);
    chk(q1 == 8'h71, "R9 cascade word", q1, 8'h71);
    // R8: async bypass shows before the edge, then persists
    setc(1, 1, 1, 1); a_in = 8'h5A;
    #1 chk(q0 == 8'h5A, "R8 immediate", q0, 8'h5A);
    chk(b_out0 == 8'h5A, "R8 bus immediate", b_out0, 8'h5A);
    step();
    setc(1, 1, 0, 0); a_in = 8'h00;
    #1 chk(q0 == 8'h5A, "R8 stored", q0, 8'h5A);
    step();

    // random mix
    for (int n = 0; n < 400; n++) begin
      setc(1'($urandom), 1'($urandom % 3 != 0), 1'($urandom), 1'($urandom));
      ser_in = 1'($urandom);
      a_in = 8'($urandom);
      b_in = 8'($urandom);
      step();
    end

    // R1 mid-run reset
    rst = 1'b1; step(); rst = 1'b0;
    #1 chk(q0 == '0 && q1 == '0, "R1 mid-run reset", q0 | q1, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule